// File: doc/BRIEF.md
# Two-Vector Byte Exchange Shuffler

This block rearranges the bytes of two equal-length vectors through a butterfly network of exchange stages. Stage s works at a distance of 2^s bytes. When it is enabled, every byte of the first vector whose index has that distance bit clear trades places with the byte of the second vector that lies that distance higher. A runtime control word chooses which stages run. Stage s is enabled by the control bit whose numeric value equals its distance, which is bit s. With the default 128-byte vectors there are seven stages, at distances 1, 2, 4, 8, 16, 32 and 64.

The network is iterative and applies one stage per clock, always in ascending distance order. A start pulse captures both operands and the control word. Seven stage cycles follow, and a one-cycle done pulse closes the operation. A disabled stage still uses its cycle, so the latency never depends on the control word. Both results stay on the outputs until the next accepted start. The operands are captured into separate registers, so the result is correct when the same value drives both inputs.

The controller has three states: IDLE, RUN and DONE. IDLE moves to RUN on start, and otherwise stays in IDLE. RUN stays in RUN while the stage counter is below its last value, and moves to DONE after the last stage. DONE moves to RUN on start (a back-to-back launch), and otherwise moves to IDLE.

Top module: `byte_xchg_shuffler`

## Requirements
- R1: After reset, busy_o and done_o are low, and both result outputs are all zero.
- R2: A start_i seen in IDLE or DONE captures vec_a_i, vec_b_i and ctrl_i at that clock edge; busy_o is high from the next cycle, and during RUN the result outputs show the working registers.
- R3: Stages run in ascending distance order 1, 2, 4, ..., NBYTES/2; stage s (distance 2^s) acts only when ctrl bit s is 1.
- R4: In an active stage of distance d, for every byte index k (byte k occupies bits 8k+7..8k) with k & d == 0, byte k of the first vector and byte k+d of the second vector swap; all other bytes keep their value.
- R5: Driving the same value on both vector inputs gives the same result as two independent copies of that value.
- R6: Control bits at positions log2(NBYTES) and above have no effect on the results.
- R7: With all low control bits zero, both results equal the captured inputs.
- R8: done_o is high for exactly one cycle, seen 8 cycles after the cycle in which start_i was driven, whatever the control word.
- R9: A start_i that arrives while busy_o is high is ignored, and the running operation finishes with its own operands.
- R10: Outside RUN and without a new start, both results hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, sampled in IDLE or DONE |
| ctrl_i | input | CTRL_W | Stage enable word; bit s enables distance 2^s |
| vec_a_i | input | NBYTES*8 | First operand vector, byte k at bits 8k+7..8k |
| vec_b_i | input | NBYTES*8 | Second operand vector, same byte order |
| busy_o | output | 1 | High while stages are being applied |
| done_o | output | 1 | One-cycle completion pulse |
| res_a_o | output | NBYTES*8 | First result vector |
| res_b_o | output | NBYTES*8 | Second result vector |

## Verification
A behavioural model in the bench steps through the stages and is compared with the outputs on every clock. Separately, each finished result is compared with a whole-word reference that walks the distances by their value.

Single-bit control words isolate each stage. A design that reverses the exchange direction, or that indexes the wrong vector, shows up there on the first stage. Control words with only high bits set catch a design that decodes bits above the last stage. A pair of identical operands catches a design that aliases its two working copies.

A start pulse injected mid-run catches a design that reloads while busy. A launch in the done cycle catches a controller that drops back-to-back requests. A latency count taken with all stages off and with all stages on catches a design that skips disabled stages.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    // Controller states of the exchange sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bxs_state_e;

endpackage

// File: rtl/bxs_stage.sv
// One butterfly exchange layer at a fixed byte distance.
module bxs_stage #(
    parameter int NBYTES = 128,
    parameter int OFFSET = 1
) (
    input  logic [NBYTES*8-1:0] a_i,
    input  logic [NBYTES*8-1:0] b_i,
    output logic [NBYTES*8-1:0] a_o,
    output logic [NBYTES*8-1:0] b_o
);

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        if ((k & OFFSET) == 0) begin : g_lo
            // low half of a pair: first vector takes the partner from the second
            assign a_o[k*8 +: 8] = b_i[(k+OFFSET)*8 +: 8];
            assign b_o[k*8 +: 8] = b_i[k*8 +: 8];
        end else begin : g_hi
            // high half of a pair: second vector receives the displaced byte
            assign a_o[k*8 +: 8] = a_i[k*8 +: 8];
            assign b_o[k*8 +: 8] = a_i[(k-OFFSET)*8 +: 8];
        end
    end

endmodule

// File: rtl/bxs_net.sv
// All exchange layers side by side; the stage index picks one, or none.
module bxs_net #(
    parameter int NBYTES = 128,
    parameter int STAGES = 7,
    parameter int SEL_W  = 3
) (
    input  logic [NBYTES*8-1:0] a_i,
    input  logic [NBYTES*8-1:0] b_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                en_i,
    output logic [NBYTES*8-1:0] a_o,
    output logic [NBYTES*8-1:0] b_o
);

    localparam int VW = NBYTES * 8;

    logic [VW-1:0] st_a [STAGES];
    logic [VW-1:0] st_b [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        bxs_stage #(
            .NBYTES (NBYTES),
            .OFFSET (1 << s)
        ) u_stage (
            .a_i (a_i),
            .b_i (b_i),
            .a_o (st_a[s]),
            .b_o (st_b[s])
        );
    end

    always_comb begin
        a_o = a_i;
        b_o = b_i;
        for (int s = 0; s < STAGES; s++) begin
            if (en_i && (sel_i == SEL_W'(s))) begin
                a_o = st_a[s];
                b_o = st_b[s];
            end
        end
    end

endmodule

// File: rtl/bxs_ctrl.sv
// Sequencer: IDLE -> RUN (one stage per cycle) -> DONE.
module bxs_ctrl
    import bxs_pkg::*;
#(
    parameter int STAGES = 7,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             load_o,
    output logic             step_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [SEL_W-1:0] LAST = SEL_W'(STAGES - 1);

    bxs_state_e       state_q, state_d;
    logic [SEL_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (cnt_q == LAST) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        sel_o  = cnt_q;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: begin
                load_o = 1'b0;
            end
        endcase
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> ($past(state_q) == ST_RUN && $past(cnt_q) == LAST));

endmodule

// File: rtl/bxs_dpath.sv
// Working registers for both vectors and the captured stage enables.
module bxs_dpath #(
    parameter int NBYTES = 128,
    parameter int STAGES = 7,
    parameter int SEL_W  = 3,
    parameter int CTRL_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [NBYTES*8-1:0] vec_a_i,
    input  logic [NBYTES*8-1:0] vec_b_i,
    input  logic [CTRL_W-1:0]   ctrl_i,
    output logic [NBYTES*8-1:0] res_a_o,
    output logic [NBYTES*8-1:0] res_b_o
);

    localparam int VW = NBYTES * 8;

    logic [VW-1:0]     a_q, b_q;
    logic [VW-1:0]     net_a, net_b;
    logic [STAGES-1:0] ctrl_q;
    logic              stage_en;

    // only the bits that name a stage are kept
    always_comb begin
        stage_en = 1'b0;
        for (int s = 0; s < STAGES; s++) begin
            if (sel_i == SEL_W'(s)) stage_en = ctrl_q[s];
        end
    end

    bxs_net #(
        .NBYTES (NBYTES),
        .STAGES (STAGES),
        .SEL_W  (SEL_W)
    ) u_net (
        .a_i   (a_q),
        .b_i   (b_q),
        .sel_i (sel_i),
        .en_i  (stage_en),
        .a_o   (net_a),
        .b_o   (net_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            ctrl_q <= '0;
        end else if (load_i) begin
            a_q    <= vec_a_i;
            b_q    <= vec_b_i;
            ctrl_q <= ctrl_i[STAGES-1:0];
        end else if (step_i) begin
            a_q    <= net_a;
            b_q    <= net_b;
        end
    end

    assign res_a_o = a_q;
    assign res_b_o = b_q;

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (a_q == $past(vec_a_i) && b_q == $past(vec_b_i)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/byte_xchg_shuffler.sv
module byte_xchg_shuffler #(
    parameter int NBYTES = 128,
    parameter int CTRL_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CTRL_W-1:0]   ctrl_i,
    input  logic [NBYTES*8-1:0] vec_a_i,
    input  logic [NBYTES*8-1:0] vec_b_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [NBYTES*8-1:0] res_a_o,
    output logic [NBYTES*8-1:0] res_b_o
);

    localparam int STAGES = $clog2(NBYTES);
    localparam int SEL_W  = (STAGES > 1) ? $clog2(STAGES) : 1;

    logic             load, step;
    logic [SEL_W-1:0] sel;

    bxs_ctrl #(
        .STAGES (STAGES),
        .SEL_W  (SEL_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .sel_o   (sel),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    bxs_dpath #(
        .NBYTES (NBYTES),
        .STAGES (STAGES),
        .SEL_W  (SEL_W),
        .CTRL_W (CTRL_W)
    ) u_dpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .sel_i   (sel),
        .vec_a_i (vec_a_i),
        .vec_b_i (vec_b_i),
        .ctrl_i  (ctrl_i),
        .res_a_o (res_a_o),
        .res_b_o (res_b_o)
    );

    // R9
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |-> !load);

endmodule

// File: tb/byte_xchg_shuffler_bench.sv
module byte_xchg_shuffler_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 128;
    localparam int VW         = NB * 8;
    localparam int WD_LIMIT   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   ctrl = '0;
    logic [VW-1:0] va = '0;
    logic [VW-1:0] vb = '0;
    logic          busy, done;
    logic [VW-1:0] ra, rb;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_xchg_shuffler #(.NBYTES(NB), .CTRL_W(32)) u_byte_xchg_shuffler (
        .clk (clk), .rst_n (rst_n), .start_i (start), .ctrl_i (ctrl),
        .vec_a_i (va), .vec_b_i (vb), .busy_o (busy), .done_o (done),
        .res_a_o (ra), .res_b_o (rb)
    );

    // one exchange at distance 2^s, on byte arrays
    function automatic logic [2*VW-1:0] stage_ref(input logic [VW-1:0] a,
                                                   input logic [VW-1:0] b,
                                                   input int s);
        logic [7:0] x [NB];
        logic [7:0] y [NB];
        logic [7:0] t;
        logic [VW-1:0] oa, ob;
        int d;
        d = 1 << s;
        for (int k = 0; k < NB; k++) begin
            x[k] = a[k*8 +: 8];
            y[k] = b[k*8 +: 8];
        end
        for (int k = 0; k < NB; k++) begin
            if ((k & d) == 0) begin
                t = x[k];
                x[k] = y[k+d];
                y[k+d] = t;
            end
        end
        for (int k = 0; k < NB; k++) begin
            oa[k*8 +: 8] = x[k];
            ob[k*8 +: 8] = y[k];
        end
        return {ob, oa};
    endfunction

    // whole operation: walk distances by value, bit with that value gates
    function automatic logic [2*VW-1:0] full_ref(input logic [VW-1:0] a,
                                                  input logic [VW-1:0] b,
                                                  input logic [31:0] c);
        logic [2*VW-1:0] r;
        int s;
        r = {b, a};
        s = 0;
        for (int d = 1; d < NB; d = d * 2) begin
            if ((c & d) != 0) r = stage_ref(r[VW-1:0], r[2*VW-1:VW], s);
            s++;
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] pat(input int seed);
        logic [VW-1:0] v;
        for (int k = 0; k < NB; k++) v[k*8 +: 8] = 8'((k * seed + k * k + 3 * seed) & 255);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // cycle-by-cycle behavioural model
    logic [VW-1:0] m_a = '0, m_b = '0;
    logic [31:0]   m_ctrl = '0;
    int            m_cnt = 0;
    bit            m_busy = 0, m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a <= '0; m_b <= '0; m_ctrl <= '0; m_cnt <= 0;
            m_busy <= 0; m_done <= 0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                if (m_ctrl[m_cnt]) {m_b, m_a} <= stage_ref(m_a, m_b, m_cnt);
                if (m_cnt == 6) begin
                    m_busy <= 0;
                    m_done <= 1;
                end
                m_cnt <= m_cnt + 1;
            end else if (start) begin
                m_a <= va; m_b <= vb; m_ctrl <= ctrl; m_cnt <= 0; m_busy <= 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R2 busy per-cycle", VW'(busy), VW'(m_busy));
            chk(done == m_done, "R8 done per-cycle", VW'(done), VW'(m_done));
            chk(ra == m_a, "R4 res_a per-cycle", ra, m_a);
            chk(rb == m_b, "R4 res_b per-cycle", rb, m_b);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            failures++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    task automatic launch(input logic [VW-1:0] a, input logic [VW-1:0] b,
                          input logic [31:0] c);
        va = a; vb = b; ctrl = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_chk(input logic [VW-1:0] a, input logic [VW-1:0] b,
                           input logic [31:0] c, input string tag);
        logic [2*VW-1:0] e;
        int lat;
        e = full_ref(a, b, c);
        launch(a, b, c);
        wait_done(lat);
        chk(ra == e[VW-1:0], {tag, " res_a"}, ra, e[VW-1:0]);
        chk(rb == e[2*VW-1:VW], {tag, " res_b"}, rb, e[2*VW-1:VW]);
    endtask

    initial begin
        logic [2*VW-1:0] e, e2;
        logic [VW-1:0]   sa, sb;
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 flags after reset", VW'({busy, done}), '0);
        chk(ra == '0 && rb == '0, "R1 results after reset", ra | rb, '0);

        // R7 no stages enabled
        run_chk(pat(5), pat(11), 32'h0, "R7 zero control");
        chk(ra == pat(5) && rb == pat(11), "R7 passthrough", ra, pat(5));

        // R3 R4 each stage on its own
        for (int s = 0; s < 7; s++) run_chk(pat(s + 2), pat(s + 40), 32'd1 << s, "R4 single stage");

        // R3 all stages and mixed words
        run_chk(pat(7), pat(9), 32'h7f, "R3 all stages");
        run_chk(pat(13), pat(17), 32'h29, "R3 mixed stages");

        // R6 upper control bits
        e = full_ref(pat(21), pat(23), 32'h15);
        run_chk(pat(21), pat(23), 32'hABCDEF95, "R6 upper bits");
        chk(ra == e[VW-1:0] && rb == e[2*VW-1:VW], "R6 same as low bits only", ra, e[VW-1:0]);
        run_chk(pat(3), pat(4), 32'hFFFFFF80, "R6 only upper bits");
        chk(ra == pat(3) && rb == pat(4), "R6 upper-only passthrough", ra, pat(3));

        // R5 same operand on both inputs
        sa = {NB/4{32'h089be55c}};
        run_chk(sa, sa, 32'h454fa926, "R5 shared operand");

        // R8 fixed latency
        launch(pat(1), pat(2), 32'h0);
        wait_done(lat);
        chk(lat == 8, "R8 latency zero ctrl", VW'(lat), VW'(8));
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", VW'(done), '0);
        launch(pat(1), pat(2), 32'h7f);
        wait_done(lat);
        chk(lat == 8, "R8 latency full ctrl", VW'(lat), VW'(8));

        // R2 back-to-back: launch during the done cycle
        e = full_ref(pat(31), pat(33), 32'h4a);
        launch(pat(31), pat(33), 32'h4a);
        wait_done(lat);
        chk(lat == 8 && ra == e[VW-1:0] && rb == e[2*VW-1:VW], "R2 launch in done cycle",
            ra, e[VW-1:0]);

        // R9 start while busy is ignored
        e = full_ref(pat(41), pat(43), 32'h33);
        launch(pat(41), pat(43), 32'h33);
        repeat (2) @(negedge clk);
        launch(pat(50), pat(51), 32'h7f);
        wait_done(lat);
        chk(ra == e[VW-1:0] && rb == e[2*VW-1:VW], "R9 mid-run start ignored", ra, e[VW-1:0]);

        // R10 results held while idle
        sa = ra; sb = rb;
        va = pat(60); vb = pat(61); ctrl = 32'h7f;
        repeat (5) @(negedge clk);
        chk(ra == sa && rb == sb, "R10 hold after done", ra, sa);
        e2 = full_ref(pat(60), pat(61), 32'h7f);
        run_chk(pat(60), pat(61), 32'h7f, "R10 next op after hold");
        chk(busy == 1'b0, "R2 busy low at done", VW'(busy), '0);

        repeat (3) @(negedge clk);
        chk(ra == e2[VW-1:0], "R10 hold final", ra, e2[VW-1:0]);
        finish_run();
    end

endmodule